// File: doc/BRIEF.md
# Hashed Page Table Group Index Generator

This block turns a virtual page number into the two candidate group locations of a hashed page table. The page number is cut into a segment part and a page part, with the cut point set by a large-page flag. The segment part is cut down to a fixed width and XORed with the page part. The hash and its bitwise complement are each ANDed with a software-loaded table mask. This gives a primary and a secondary group index. Each index is also given as a byte offset of the group's first entry.

Requests arrive on a valid/ready handshake. The result is registered and shown with a valid strobe until the consumer takes it. Only one result is held, so a new request is refused while a result waits. The mask register is loaded through a write strobe. That write takes effect only when the block is fully idle. Fetching table memory, comparing entries and inserting entries are done outside this block.

Top module: `hpt_group_index`

## Requirements
- R1: After the active-low synchronous reset, rsp_valid is 0, req_ready is 1, and the mask register is 0, so a request made before any mask write returns index 0 for both groups.
- R2: With req_large = 0, the segment part is req_vpn shifted right by 16 and the page part is req_vpn[15:0].
- R3: With req_large = 1, the segment part is req_vpn shifted right by 4 and the page part is req_vpn[3:0].
- R4: Only the low 39 bits of the segment part enter the hash, so page-number bits above that slice have no effect on the result. The hash is this 39-bit value XORed with the zero-extended page part.
- R5: rsp_prim_idx is the 39-bit hash ANDed with the mask register.
- R6: rsp_sec_idx is the bitwise complement of the 39-bit hash, ANDed with the mask register.
- R7: rsp_prim_off and rsp_sec_off are the matching index times 128 (8 entries of 16 bytes), 46 bits wide with the low 7 bits zero.
- R8: A request accepted at a clock edge gives rsp_valid = 1 after that edge. While rsp_valid is 1 and rsp_ready is 0, rsp_valid and all result fields hold steady.
- R9: req_ready is 0 whenever rsp_valid is 1. Results come out in the order their requests were accepted.
- R10: A mask write (mask_we = 1) is loaded only in a cycle where req_valid = 0 and rsp_valid = 0. At any other time it is dropped and the previous mask stays in force, including when a request is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | 64 | Virtual page number |
| req_large | input | 1 | 1 = large page, 0 = small page |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 39 | New hash mask value |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_prim_idx | output | 39 | Primary group index |
| rsp_sec_idx | output | 39 | Secondary group index |
| rsp_prim_off | output | 46 | Byte offset of primary group |
| rsp_sec_off | output | 46 | Byte offset of secondary group |

## Verification
Two events can land in the same cycle: a mask write and a request acceptance. When they do, the request must be hashed with the old mask and the write must be lost. The bench provokes this by raising mask_we and req_valid together while the block is idle. It also writes the mask while a result is stalled by a low rsp_ready. After each case, a later request shows at the outputs which mask is in force. The scoreboard judges every result against a mask model that is updated only under the idle rule.

// File: rtl/hpt_idx_pkg.sv
package hpt_idx_pkg;

    // Page size select as carried on the request
    typedef enum logic {
        PG_SMALL = 1'b0,
        PG_LARGE = 1'b1
    } pg_size_e;

    localparam int unsigned DEF_VPN_W        = 64;
    localparam int unsigned DEF_HASH_W       = 39;
    localparam int unsigned DEF_SMALL_BITS   = 16;
    localparam int unsigned DEF_LARGE_BITS   = 4;
    localparam int unsigned DEF_GRP_ENTRIES  = 8;
    localparam int unsigned DEF_ENTRY_BYTES  = 16;

endpackage

// File: rtl/hpt_split.sv
// Cuts a page number at a fixed point into a truncated segment part
// and a zero-extended page part, both HASH_W wide.
module hpt_split #(
    parameter int unsigned VPN_W  = 64,
    parameter int unsigned HASH_W = 39,
    parameter int unsigned SHIFT  = 16
) (
    input  logic [VPN_W-1:0]  vpn,
    output logic [HASH_W-1:0] seg_part,
    output logic [HASH_W-1:0] pg_part
);
    localparam int unsigned PAD_W = HASH_W - SHIFT;

    always_comb begin
        seg_part = HASH_W'(vpn >> SHIFT);
        pg_part  = {{PAD_W{1'b0}}, vpn[SHIFT-1:0]};
    end
endmodule

// File: rtl/hpt_hash_fold.sv
// Builds one splitter per page size, picks one by the size flag and folds.
module hpt_hash_fold
    import hpt_idx_pkg::*;
#(
    parameter int unsigned VPN_W      = 64,
    parameter int unsigned HASH_W     = 39,
    parameter int unsigned SMALL_BITS = 16,
    parameter int unsigned LARGE_BITS = 4
) (
    input  logic [VPN_W-1:0]  vpn,
    input  pg_size_e          size,
    output logic [HASH_W-1:0] hash
);
    localparam int unsigned N_SIZES = 2;

    logic [HASH_W-1:0] seg_v [N_SIZES];
    logic [HASH_W-1:0] pg_v  [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int unsigned SH = (g == int'(PG_LARGE)) ? LARGE_BITS : SMALL_BITS;
        hpt_split #(
            .VPN_W (VPN_W),
            .HASH_W(HASH_W),
            .SHIFT (SH)
        ) u_split (
            .vpn     (vpn),
            .seg_part(seg_v[g]),
            .pg_part (pg_v[g])
        );
    end

    always_comb begin
        if (size == PG_LARGE) begin
            hash = seg_v[1] ^ pg_v[1];
        end else begin
            hash = seg_v[0] ^ pg_v[0];
        end
    end
endmodule

// File: rtl/hpt_mask_reg.sv
// Table hash mask, loaded only while the datapath is idle.
module hpt_mask_reg #(
    parameter int unsigned W = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         idle,
    output logic [W-1:0] mask_q
);
    logic [W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (we && idle) begin
            mask_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    // R10
    mask_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(we && idle));
endmodule

// File: rtl/hpt_group_index.sv
module hpt_group_index
    import hpt_idx_pkg::*;
#(
    parameter int unsigned VPN_W       = DEF_VPN_W,
    parameter int unsigned HASH_W      = DEF_HASH_W,
    parameter int unsigned SMALL_BITS  = DEF_SMALL_BITS,
    parameter int unsigned LARGE_BITS  = DEF_LARGE_BITS,
    parameter int unsigned GRP_ENTRIES = DEF_GRP_ENTRIES,
    parameter int unsigned ENTRY_BYTES = DEF_ENTRY_BYTES,
    localparam int unsigned GRP_SHIFT  = $clog2(GRP_ENTRIES * ENTRY_BYTES),
    localparam int unsigned OFF_W      = HASH_W + GRP_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic              req_large,
    input  logic              mask_we,
    input  logic [HASH_W-1:0] mask_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [HASH_W-1:0] rsp_prim_idx,
    output logic [HASH_W-1:0] rsp_sec_idx,
    output logic [OFF_W-1:0]  rsp_prim_off,
    output logic [OFF_W-1:0]  rsp_sec_off
);
    typedef struct packed {
        logic              valid;
        logic [HASH_W-1:0] prim;
        logic [HASH_W-1:0] sec;
    } rsp_st_t;

    rsp_st_t           st_d, st_q;
    logic [HASH_W-1:0] hash;
    logic [HASH_W-1:0] mask_q;
    logic              accept;
    logic              idle;

    hpt_hash_fold #(
        .VPN_W     (VPN_W),
        .HASH_W    (HASH_W),
        .SMALL_BITS(SMALL_BITS),
        .LARGE_BITS(LARGE_BITS)
    ) u_fold (
        .vpn (req_vpn),
        .size(pg_size_e'(req_large)),
        .hash(hash)
    );

    hpt_mask_reg #(
        .W(HASH_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (mask_wdata),
        .idle  (idle),
        .mask_q(mask_q)
    );

    always_comb begin
        st_d   = st_q;
        accept = req_valid && !st_q.valid;
        idle   = !req_valid && !st_q.valid;
        if (st_q.valid && rsp_ready) begin
            st_d.valid = 1'b0;
        end
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.prim  = hash & mask_q;
            st_d.sec   = ~hash & mask_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = !st_q.valid;
    assign rsp_valid    = st_q.valid;
    assign rsp_prim_idx = st_q.prim;
    assign rsp_sec_idx  = st_q.sec;
    assign rsp_prim_off = {st_q.prim, {GRP_SHIFT{1'b0}}};
    assign rsp_sec_off  = {st_q.sec,  {GRP_SHIFT{1'b0}}};

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_prim_idx)
                                       && $stable(rsp_sec_idx)));

    // R6
    disjoint_groups_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_prim_idx & rsp_sec_idx) == '0));
endmodule

// File: tb/hpt_group_index_tb.sv
module hpt_group_index_tb;
    localparam int HW = 39;
    localparam int OW = 46;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [63:0]   req_vpn = '0;
    logic          req_large = 1'b0;
    logic          mask_we = 1'b0;
    logic [HW-1:0] mask_wdata = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [HW-1:0] rsp_prim_idx, rsp_sec_idx;
    logic [OW-1:0] rsp_prim_off, rsp_sec_off;

    always #2 clk = ~clk;

    hpt_group_index u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_large(req_large),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_prim_idx(rsp_prim_idx), .rsp_sec_idx(rsp_sec_idx),
        .rsp_prim_off(rsp_prim_off), .rsp_sec_off(rsp_sec_off)
    );

    typedef struct {
        logic [HW-1:0] prim;
        logic [HW-1:0] sec;
        logic [OW-1:0] poff;
        logic [OW-1:0] soff;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_run  = 0;
    int            n_fail = 0;
    logic [HW-1:0] mask_m = '0;
    int            ready_mode = 0;
    logic          mon_on = 1'b0;
    logic          done = 1'b0;

    function automatic exp_t model(logic [63:0] vpn, logic lg, logic [HW-1:0] m, string tag);
        exp_t          e;
        logic [63:0]   seg;
        logic [63:0]   pg;
        logic [HW-1:0] h;
        seg = lg ? (vpn >> 4) : (vpn >> 16);
        pg  = lg ? (vpn & 64'hF) : (vpn & 64'hFFFF);
        h   = seg[HW-1:0] ^ pg[HW-1:0];
        e.prim = h & m;
        e.sec  = (~h) & m;
        e.poff = OW'(e.prim) * 128;
        e.soff = OW'(e.sec) * 128;
        e.tag  = tag;
        return e;
    endfunction

    task automatic check(logic ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: called at a negedge, returns at a negedge
    task automatic send(logic [63:0] vpn, logic lg, string tag);
        req_valid = 1'b1; req_vpn = vpn; req_large = lg;
        forever begin
            if (req_ready) break;
            @(negedge clk);
        end
        sb.push_back(model(vpn, lg, mask_m, tag));
        @(negedge clk);
        check(rsp_valid == 1'b1, "R8", "valid after accept", 64'(rsp_valid), 64'd1);
        req_valid = 1'b0;
    endtask

    task automatic wr_mask(logic [HW-1:0] v);
        mask_we = 1'b1; mask_wdata = v;
        if (!req_valid && !rsp_valid) mask_m = v;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    // Mask write and request in the same cycle
    task automatic collide(logic [63:0] vpn, logic lg, logic [HW-1:0] v);
        while (rsp_valid) @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_large = lg;
        mask_we = 1'b1; mask_wdata = v;
        check(req_ready == 1'b1, "R10", "ready in collision", 64'(req_ready), 64'd1);
        sb.push_back(model(vpn, lg, mask_m, "R10"));
        @(negedge clk);
        req_valid = 1'b0; mask_we = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || rsp_valid) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        logic          prev_stall = 1'b0;
        logic [HW-1:0] pp = '0, ps = '0;
        int            cyc = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                cyc++;
                if (prev_stall) begin
                    check(rsp_valid == 1'b1, "R8", "valid held", 64'(rsp_valid), 64'd1);
                    check(rsp_prim_idx == pp && rsp_sec_idx == ps, "R8", "data held",
                          64'(rsp_prim_idx), 64'(pp));
                end
                if (rsp_valid)
                    check(req_ready == 1'b0, "R9", "ready while full", 64'(req_ready), 64'd0);
                case (ready_mode)
                    0: rsp_ready = 1'b1;
                    1: rsp_ready = cyc[0] ^ cyc[2];
                    default: rsp_ready = 1'b0;
                endcase
                if (rsp_valid && rsp_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R9", "unexpected result", 64'(rsp_prim_idx), 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(rsp_prim_idx == e.prim, e.tag, "prim idx (R5)", 64'(rsp_prim_idx), 64'(e.prim));
                        check(rsp_sec_idx == e.sec, e.tag, "sec idx (R6)", 64'(rsp_sec_idx), 64'(e.sec));
                        check(rsp_prim_off == e.poff && rsp_sec_off == e.soff, e.tag, "offsets (R7)",
                              64'(rsp_prim_off), 64'(e.poff));
                    end
                end
                prev_stall = rsp_valid && !rsp_ready;
                pp = rsp_prim_idx; ps = rsp_sec_idx;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", "valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "idle after reset",
              64'({rsp_valid, req_ready}), 64'b01);
        mon_on = 1'b1;
        // R1 mask zero after reset gives zero indices
        send(64'h0000_1234_5678_9ABC, 1'b0, "R1");
        drain();

        wr_mask({HW{1'b1}});
        // R2 small pages
        send(64'h0000_0000_0001_0000, 1'b0, "R2");
        send(64'h0000_00AB_CDEF_1357, 1'b0, "R2");
        send(64'h0000_0000_0000_FFFF, 1'b0, "R2");
        // R3 large pages
        send(64'h0000_0000_0000_0010, 1'b1, "R3");
        send(64'h0000_0012_3456_789F, 1'b1, "R3");
        send(64'h0000_0000_0000_0007, 1'b1, "R3");
        // R4 bits above the segment slice ignored
        send(64'hFF80_0000_0001_2345, 1'b0, "R4");
        send(64'h0080_0000_0001_2345, 1'b0, "R4");
        send(64'hFFFF_F800_0000_0001, 1'b1, "R4");
        drain();

        // R5 R6 R7 partial mask
        wr_mask(39'h7FF);
        send(64'h0000_0003_C5A5_0F0F, 1'b0, "R5");
        send(64'h0000_0000_0BAD_BEEF, 1'b1, "R6");
        send(64'h0000_7FFF_FFFF_FFFF, 1'b0, "R7");
        drain();

        // R8 R9 backpressure with back-to-back requests
        ready_mode = 1;
        for (int i = 0; i < 12; i++)
            send(64'h0000_0102_0304_0000 + 64'(i) * 64'h1_0011, 1'(i % 2), "R9");
        drain();

        // R10 mask write together with a request: request wins
        ready_mode = 0;
        collide(64'h0000_0000_0055_AA33, 1'b0, 39'h3);
        send(64'h0000_0000_0055_AA33, 1'b1, "R10");
        drain();

        // R10 mask write while a result is stalled is dropped
        ready_mode = 2;
        send(64'h0000_0000_00FE_DCBA, 1'b0, "R8");
        wr_mask(39'h1);
        repeat (3) @(negedge clk);
        ready_mode = 0;
        drain();
        send(64'h0000_0000_00FE_DCBA, 1'b1, "R10");
        drain();
        // R10 idle write now applies
        wr_mask(39'h1F);
        send(64'h0000_0000_00FE_DCBA, 1'b1, "R10");
        drain();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule